// File: doc/BRIEF.md
# Multi-Group Conversion Trigger Sequencer

This block decides when an analog-to-digital conversion begins and which input channel it uses. It keeps a small bank of channel-group registers. Each register holds a 5-bit channel number and an enable for the completion interrupt. Only one group owns the converter at a time. The block runs that group through a timed sample phase and then a bit-decision phase. It sends a one-cycle start pulse to the converter core and waits for the core's done signal. When the conversion finishes, it raises a one-cycle completion strobe on the group's own lane.

The block has two trigger modes. In software mode, only a register write to group 0 starts a conversion, and writes to the other groups only store data. In hardware mode, each group has a trigger input. Triggers that arrive while the converter is busy are held as pending and served from the lowest group number upward, so the groups take turns. Rewriting the group that owns the converter aborts its conversion. Rewriting any other group does not disturb the conversion in progress. Continuous mode starts the same group again straight after each completion.

Top module: `conv_seq_top`

## Requirements
- R1: Each group register stores a channel number (0 to 31) and an interrupt enable. `cnv_chan_o` shows the channel of the owning group. `irq_o[g]` pulses together with `done_strb_o[g]` only when group g's interrupt enable is 1.
- R2: With `hw_trig_en_i` = 0, a write to group 0 while the block is idle starts a conversion on group 0 at that clock edge. A write to group 1 or above never starts one.
- R3: With `hw_trig_en_i` = 1, a pulse on `hw_trig_i[g]` starts group g, and register writes start nothing, including writes to group 0.
- R4: A hardware trigger that arrives while the block is busy is held per group. When the block is free, held triggers and simultaneous triggers are served lowest group number first.
- R5: At most one group owns the converter. `done_strb_o` has at most one bit set. `act_grp_o` and `cnv_chan_o` stay constant for as long as `busy_o` stays high.
- R6: The sample phase lasts 2, 4, 6 or 8 converter clocks when `cfg_long_i` = 0, and 12, 16, 20 or 24 converter clocks when `cfg_long_i` = 1. `cfg_samp_i` = 0, 1, 2 or 3 selects the value. `sampling_o` is high throughout the sample phase.
- R7: One converter clock lasts 1, 2, 4 or 8 input clock cycles, selected by `cfg_div_i` = 0, 1, 2 or 3.
- R8: The decision phase lasts 8, 10 or 12 converter clocks for `cfg_res_i` = 0, 1 or 2. Code 3 also gives 12. `cnv_start_o` is high for exactly one cycle, the first cycle of the decision phase, which comes immediately after the last sampling cycle.
- R9: After the decision phase, the block waits for `cnv_done_i`. The completion strobe is high in the cycle after `cnv_done_i` is seen. With `cnv_done_i` held high, `busy_o` stays high for (sample + decision) × divider + 1 cycles.
- R10: A write to the owning group while `busy_o` is high returns the block to idle on the next cycle. No completion strobe follows, and any held trigger for that group is discarded.
- R11: A write to a group other than the owning one while `busy_o` is high changes neither the timing of the conversion in progress nor the channel it uses.
- R12: With `cfg_cont_i` = 1, a completion immediately starts the same group again, and `busy_o` stays high between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_trig_en_i | input | 1 | 1 = hardware trigger mode, 0 = software mode |
| cfg_cont_i | input | 1 | Continuous restart enable |
| cfg_long_i | input | 1 | Long sample phase select |
| cfg_samp_i | input | 2 | Sample length code |
| cfg_div_i | input | 2 | Converter clock divider code |
| cfg_res_i | input | 2 | Resolution code |
| wr_en_i | input | 1 | Group register write strobe |
| wr_grp_i | input | 2 | Index of the group being written |
| wr_chan_i | input | 5 | Channel number to write |
| wr_ie_i | input | 1 | Interrupt enable to write |
| hw_trig_i | input | 4 | Per-group hardware trigger pulses |
| cnv_done_i | input | 1 | Converter core reports the result is ready |
| cnv_start_o | output | 1 | One-cycle pulse that starts the converter's decision phase |
| cnv_chan_o | output | 5 | Channel of the owning group |
| sampling_o | output | 1 | High during the sample phase |
| busy_o | output | 1 | High while a conversion is in progress |
| act_grp_o | output | 2 | Index of the owning group |
| done_strb_o | output | 4 | Per-group completion strobe |
| irq_o | output | 4 | Completion strobe gated by each group's interrupt enable |

## Verification
The checker watches every cycle for these properties:
- the idle state has no sampling and no start pulse, and the completion strobe sets at most one bit;
- ownership and channel do not change while busy, the start pulse lasts one cycle and follows sampling, and an interrupt never fires without its strobe;
- a write to the owning group leads to idle with no strobe;
- in software mode the block never leaves idle unless group 0 is written.

Only the bench scenarios can show the following:
- the exact phase lengths for each sample, divider and resolution code;
- the service order of held and simultaneous triggers;
- that an aborted group's held trigger is discarded;
- that the waiting state lasts until the converter answers;
- the fixed repeat period in continuous mode.

// File: rtl/conv_seq_pkg.sv
`timescale 1ns/1ps
package conv_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_DECIDE = 2'd2,
      PH_WAIT   = 2'd3
   } phase_e;

   // sample phase length in converter clocks
   function automatic logic [7:0] samp_clocks(input logic long_sel, input logic [1:0] code);
      logic [7:0] c8;
      c8 = 8'(code);
      if (long_sel) samp_clocks = 8'd12 + (c8 << 2);
      else          samp_clocks = 8'd2 + (c8 << 1);
   endfunction

   // bit-decision cycles per resolution code; code 3 treated as the widest
   function automatic logic [7:0] res_clocks(input logic [1:0] code);
      case (code)
         2'd0:    res_clocks = 8'd8;
         2'd1:    res_clocks = 8'd10;
         default: res_clocks = 8'd12;
      endcase
   endfunction

   // divider terminal count (ratio minus one)
   function automatic logic [7:0] div_last(input logic [1:0] code);
      case (code)
         2'd0:    div_last = 8'd0;
         2'd1:    div_last = 8'd1;
         2'd2:    div_last = 8'd3;
         default: div_last = 8'd7;
      endcase
   endfunction

endpackage

// File: rtl/cs_tick_gen.sv
`timescale 1ns/1ps
module cs_tick_gen #(
   parameter int DIVC_W = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic [1:0] div_code_i,
   output logic       tick_o
);
   import conv_seq_pkg::*;

   logic [7:0]        last_w;
   logic [DIVC_W-1:0] last;
   logic [DIVC_W-1:0] cnt_q;

   assign last_w = div_last(div_code_i);
   assign last   = last_w[DIVC_W-1:0];
   // >= keeps a mid-run code change from stalling the counter
   assign tick_o = run_i && (cnt_q >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run_i || tick_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   if (DIVC_W < 3 || DIVC_W > 8) begin : g_bad_divc
      $error("cs_tick_gen: DIVC_W must be 3..8");
   end
endmodule

// File: rtl/cs_group_bank.sv
`timescale 1ns/1ps
module cs_group_bank #(
   parameter int NUM_GROUPS = 4,
   parameter int CHAN_W     = 5,
   localparam int GW        = $clog2(NUM_GROUPS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en_i,
   input  logic [GW-1:0]         wr_grp_i,
   input  logic [CHAN_W-1:0]     wr_chan_i,
   input  logic                  wr_ie_i,
   input  logic [NUM_GROUPS-1:0] trig_i,
   input  logic [NUM_GROUPS-1:0] drop_i,
   input  logic                  flush_i,
   input  logic [GW-1:0]         sel_grp_i,
   output logic [CHAN_W-1:0]     sel_chan_o,
   output logic [NUM_GROUPS-1:0] ie_o,
   output logic                  req_any_o,
   output logic [GW-1:0]         req_grp_o
);
   logic [CHAN_W-1:0]     chan_arr [NUM_GROUPS];
   logic [NUM_GROUPS-1:0] pend_vec;
   logic [NUM_GROUPS-1:0] req_vec;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic [CHAN_W-1:0] chan_q;
      logic              ie_q;
      logic              pend_q;
      logic              hit;

      assign hit = wr_en_i && (wr_grp_i == GW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chan_q <= '0;
            ie_q   <= 1'b0;
         end else if (hit) begin
            chan_q <= wr_chan_i;
            ie_q   <= wr_ie_i;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                pend_q <= 1'b0;
         else if (flush_i || drop_i[g]) pend_q <= 1'b0;
         else if (trig_i[g])        pend_q <= 1'b1;
      end

      assign chan_arr[g]  = chan_q;
      assign ie_o[g]      = ie_q;
      assign pend_vec[g]  = pend_q;
   end

   assign req_vec    = (pend_vec | trig_i) & {NUM_GROUPS{!flush_i}};
   assign sel_chan_o = chan_arr[sel_grp_i];

   // lowest index wins
   always_comb begin
      req_any_o = 1'b0;
      req_grp_o = '0;
      for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
         if (req_vec[g]) begin
            req_any_o = 1'b1;
            req_grp_o = GW'(g);
         end
      end
   end
endmodule

// File: rtl/cs_phase_fsm.sv
`timescale 1ns/1ps
module cs_phase_fsm #(
   parameter int NUM_GROUPS = 4,
   parameter int PHASE_W    = 5,
   localparam int GW        = $clog2(NUM_GROUPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic [PHASE_W-1:0]   samp_len_i,
   input  logic [PHASE_W-1:0]   bit_len_i,
   input  logic                 start_req_i,
   input  logic [GW-1:0]        start_grp_i,
   input  logic                 abort_i,
   input  logic                 cont_i,
   input  logic                 done_i,
   output conv_seq_pkg::phase_e phase_o,
   output logic [GW-1:0]        grp_o,
   output logic                 take_o,
   output logic                 start_pulse_o,
   output logic                 cmpl_o
);
   import conv_seq_pkg::*;

   phase_e             phase_q;
   logic [GW-1:0]      grp_q;
   logic [PHASE_W-1:0] pcnt_q;
   logic               start_q;
   logic               cmpl_q;
   logic               samp_end;
   logic               dec_end;

   assign samp_end = tick_i && (pcnt_q >= samp_len_i - 1'b1);
   assign dec_end  = tick_i && (pcnt_q >= bit_len_i - 1'b1);
   assign take_o   = (phase_q == PH_IDLE) && start_req_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         grp_q   <= '0;
         pcnt_q  <= '0;
         start_q <= 1'b0;
         cmpl_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         cmpl_q  <= 1'b0;
         if (abort_i) begin
            phase_q <= PH_IDLE;
            pcnt_q  <= '0;
         end else begin
            case (phase_q)
               PH_IDLE: begin
                  if (start_req_i) begin
                     phase_q <= PH_SAMPLE;
                     grp_q   <= start_grp_i;
                     pcnt_q  <= '0;
                  end
               end
               PH_SAMPLE: begin
                  if (samp_end) begin
                     phase_q <= PH_DECIDE;
                     pcnt_q  <= '0;
                     start_q <= 1'b1;
                  end else if (tick_i) begin
                     pcnt_q <= pcnt_q + 1'b1;
                  end
               end
               PH_DECIDE: begin
                  if (dec_end) begin
                     phase_q <= PH_WAIT;
                     pcnt_q  <= '0;
                  end else if (tick_i) begin
                     pcnt_q <= pcnt_q + 1'b1;
                  end
               end
               default: begin
                  if (done_i) begin
                     cmpl_q  <= 1'b1;
                     phase_q <= cont_i ? PH_SAMPLE : PH_IDLE;
                  end
               end
            endcase
         end
      end
   end

   assign phase_o       = phase_q;
   assign grp_o         = grp_q;
   assign start_pulse_o = start_q;
   assign cmpl_o        = cmpl_q;
endmodule

// File: rtl/conv_seq_top.sv
`timescale 1ns/1ps
module conv_seq_top #(
   parameter int NUM_GROUPS = 4,
   parameter int CHAN_W     = 5,
   parameter int PHASE_W    = 5,
   parameter int DIVC_W     = 3,
   localparam int GW        = $clog2(NUM_GROUPS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hw_trig_en_i,
   input  logic                  cfg_cont_i,
   input  logic                  cfg_long_i,
   input  logic [1:0]            cfg_samp_i,
   input  logic [1:0]            cfg_div_i,
   input  logic [1:0]            cfg_res_i,
   input  logic                  wr_en_i,
   input  logic [GW-1:0]         wr_grp_i,
   input  logic [CHAN_W-1:0]     wr_chan_i,
   input  logic                  wr_ie_i,
   input  logic [NUM_GROUPS-1:0] hw_trig_i,
   input  logic                  cnv_done_i,
   output logic                  cnv_start_o,
   output logic [CHAN_W-1:0]     cnv_chan_o,
   output logic                  sampling_o,
   output logic                  busy_o,
   output logic [GW-1:0]         act_grp_o,
   output logic [NUM_GROUPS-1:0] done_strb_o,
   output logic [NUM_GROUPS-1:0] irq_o
);
   import conv_seq_pkg::*;

   if (NUM_GROUPS < 2 || NUM_GROUPS > 32) begin : g_bad_groups
      $error("conv_seq_top: NUM_GROUPS must be 2..32");
   end
   if (CHAN_W < 1) begin : g_bad_chan
      $error("conv_seq_top: CHAN_W must be positive");
   end
   if (PHASE_W < 5 || PHASE_W > 8) begin : g_bad_phase
      $error("conv_seq_top: PHASE_W must be 5..8");
   end

   phase_e                phase;
   logic                  tick;
   logic                  run;
   logic [7:0]            samp_w, bits_w;
   logic [PHASE_W-1:0]    samp_len, bit_len;
   logic                  req_any;
   logic [GW-1:0]         req_grp;
   logic                  start_req;
   logic [GW-1:0]         start_grp;
   logic                  take;
   logic                  abort;
   logic                  cmpl;
   logic [NUM_GROUPS-1:0] trig_m;
   logic [NUM_GROUPS-1:0] drop;
   logic [NUM_GROUPS-1:0] ie_vec;
   logic [NUM_GROUPS-1:0] act_mask;
   logic [NUM_GROUPS-1:0] req_mask;

   assign samp_w   = samp_clocks(cfg_long_i, cfg_samp_i);
   assign bits_w   = res_clocks(cfg_res_i);
   assign samp_len = samp_w[PHASE_W-1:0];
   assign bit_len  = bits_w[PHASE_W-1:0];

   assign busy_o     = (phase != PH_IDLE);
   assign sampling_o = (phase == PH_SAMPLE);
   assign run        = (phase == PH_SAMPLE) || (phase == PH_DECIDE);

   assign abort  = busy_o && wr_en_i && (wr_grp_i == act_grp_o);
   assign trig_m = hw_trig_i & {NUM_GROUPS{hw_trig_en_i}};

   assign act_mask = {{(NUM_GROUPS-1){1'b0}}, 1'b1} << act_grp_o;
   assign req_mask = {{(NUM_GROUPS-1){1'b0}}, 1'b1} << req_grp;

   assign start_req = hw_trig_en_i ? req_any : (wr_en_i && (wr_grp_i == '0));
   assign start_grp = hw_trig_en_i ? req_grp : '0;

   assign drop = ((take && hw_trig_en_i) ? req_mask : '0) | (abort ? act_mask : '0);

   cs_tick_gen #(.DIVC_W(DIVC_W)) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run),
      .div_code_i (cfg_div_i),
      .tick_o     (tick)
   );

   cs_group_bank #(.NUM_GROUPS(NUM_GROUPS), .CHAN_W(CHAN_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_grp_i   (wr_grp_i),
      .wr_chan_i  (wr_chan_i),
      .wr_ie_i    (wr_ie_i),
      .trig_i     (trig_m),
      .drop_i     (drop),
      .flush_i    (!hw_trig_en_i),
      .sel_grp_i  (act_grp_o),
      .sel_chan_o (cnv_chan_o),
      .ie_o       (ie_vec),
      .req_any_o  (req_any),
      .req_grp_o  (req_grp)
   );

   cs_phase_fsm #(.NUM_GROUPS(NUM_GROUPS), .PHASE_W(PHASE_W)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_i        (tick),
      .samp_len_i    (samp_len),
      .bit_len_i     (bit_len),
      .start_req_i   (start_req),
      .start_grp_i   (start_grp),
      .abort_i       (abort),
      .cont_i        (cfg_cont_i),
      .done_i        (cnv_done_i),
      .phase_o       (phase),
      .grp_o         (act_grp_o),
      .take_o        (take),
      .start_pulse_o (cnv_start_o),
      .cmpl_o        (cmpl)
   );

   assign done_strb_o = cmpl ? act_mask : '0;
   assign irq_o       = done_strb_o & ie_vec;
endmodule

// File: rtl/cs_seq_chk.sv
`timescale 1ns/1ps
module cs_seq_chk #(
   parameter int NUM_GROUPS = 4,
   parameter int CHAN_W     = 5,
   localparam int GW        = $clog2(NUM_GROUPS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  hw_trig_en_i,
   input logic                  wr_en_i,
   input logic [GW-1:0]         wr_grp_i,
   input logic                  cnv_start_o,
   input logic [CHAN_W-1:0]     cnv_chan_o,
   input logic                  sampling_o,
   input logic                  busy_o,
   input logic [GW-1:0]         act_grp_o,
   input logic [NUM_GROUPS-1:0] done_strb_o,
   input logic [NUM_GROUPS-1:0] irq_o
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!sampling_o && !cnv_start_o));                                   // R5
   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_strb_o));                                                         // R5
   AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(act_grp_o) && $stable(cnv_chan_o)));   // R5
   AST_IRQ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o & ~done_strb_o) == '0);                                                  // R1
   AST_STROBE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_strb_o != '0) |-> $past(busy_o));                                         // R9
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start_o |=> !cnv_start_o);                                                  // R8
   AST_START_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start_o |-> $past(sampling_o));                                             // R6
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && wr_en_i && wr_grp_i == act_grp_o) |=> (!busy_o && done_strb_o == '0)); // R10
   AST_SW_ONLY_GRP0: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_trig_en_i && !busy_o && !(wr_en_i && wr_grp_i == '0)) |=> !busy_o);       // R2
endmodule

bind conv_seq_top cs_seq_chk #(.NUM_GROUPS(NUM_GROUPS), .CHAN_W(CHAN_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hw_trig_en_i (hw_trig_en_i),
   .wr_en_i      (wr_en_i),
   .wr_grp_i     (wr_grp_i),
   .cnv_start_o  (cnv_start_o),
   .cnv_chan_o   (cnv_chan_o),
   .sampling_o   (sampling_o),
   .busy_o       (busy_o),
   .act_grp_o    (act_grp_o),
   .done_strb_o  (done_strb_o),
   .irq_o        (irq_o)
);

// File: tb/tb_conv_seq_top.sv
`timescale 1ns/1ps
module tb_conv_seq_top;
   localparam int NG = 4;
   localparam int GW = 2;
   localparam int CW = 5;
   localparam int NV = 7;

   // stimulus: long, sample code, divider code, resolution code; expected sample and busy cycles
   localparam int V_LONG [NV] = '{0, 0, 1, 1, 0, 1, 0};
   localparam int V_SAMP [NV] = '{0, 3, 0, 3, 1, 2, 2};
   localparam int V_DIV  [NV] = '{0, 1, 0, 3, 2, 1, 0};
   localparam int V_RES  [NV] = '{0, 2, 1, 2, 1, 0, 3};
   localparam int V_ESMP [NV] = '{2, 16, 12, 192, 16, 40, 6};
   localparam int V_EBSY [NV] = '{11, 41, 23, 289, 57, 57, 19};

   logic          clk = 1'b0;
   logic          rst_n;
   logic          hw_trig_en_i, cfg_cont_i, cfg_long_i;
   logic [1:0]    cfg_samp_i, cfg_div_i, cfg_res_i;
   logic          wr_en_i;
   logic [GW-1:0] wr_grp_i;
   logic [CW-1:0] wr_chan_i;
   logic          wr_ie_i;
   logic [NG-1:0] hw_trig_i;
   logic          cnv_done_i;
   logic          cnv_start_o, sampling_o, busy_o;
   logic [CW-1:0] cnv_chan_o;
   logic [GW-1:0] act_grp_o;
   logic [NG-1:0] done_strb_o, irq_o;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   conv_seq_top dut (
      .clk(clk), .rst_n(rst_n), .hw_trig_en_i(hw_trig_en_i), .cfg_cont_i(cfg_cont_i),
      .cfg_long_i(cfg_long_i), .cfg_samp_i(cfg_samp_i), .cfg_div_i(cfg_div_i),
      .cfg_res_i(cfg_res_i), .wr_en_i(wr_en_i), .wr_grp_i(wr_grp_i), .wr_chan_i(wr_chan_i),
      .wr_ie_i(wr_ie_i), .hw_trig_i(hw_trig_i), .cnv_done_i(cnv_done_i),
      .cnv_start_o(cnv_start_o), .cnv_chan_o(cnv_chan_o), .sampling_o(sampling_o),
      .busy_o(busy_o), .act_grp_o(act_grp_o), .done_strb_o(done_strb_o), .irq_o(irq_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic grp_write(input int g, input int ch, input bit ie);
      @(negedge clk);
      wr_en_i = 1'b1; wr_grp_i = GW'(g); wr_chan_i = CW'(ch); wr_ie_i = ie;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic trig_pulse(input logic [NG-1:0] m);
      @(negedge clk);
      hw_trig_i = m;
      @(negedge clk);
      hw_trig_i = '0;
   endtask

   task automatic measure(output int nb, output int ns, output int nst, output int fst,
                          output logic [NG-1:0] strb, output logic [NG-1:0] irq);
      nb = 0; ns = 0; nst = 0; fst = -1;
      while (busy_o && nb < 2000) begin
         if (sampling_o) ns++;
         if (cnv_start_o) begin
            nst++;
            if (fst < 0) fst = nb;
         end
         nb++;
         @(negedge clk);
      end
      strb = done_strb_o;
      irq  = irq_o;
   endtask

   task automatic wait_strobe(input int lim, output int g, output int waited);
      g = -1; waited = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         waited++;
         if (done_strb_o != '0) begin
            for (int k = 0; k < NG; k++) if (done_strb_o[k]) g = k;
            break;
         end
      end
   endtask

   task automatic quiet_for(input int n, output int seen_busy, output int seen_strb);
      seen_busy = 0; seen_strb = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (busy_o) seen_busy++;
         if (done_strb_o != '0) seen_strb++;
      end
   endtask

   task automatic cfg_fast();
      cfg_long_i = 1'b0; cfg_samp_i = 2'd0; cfg_div_i = 2'd0; cfg_res_i = 2'd0;
   endtask

   initial begin
      #(5.0 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int nb, ns, nst, fst, g, w, sb, ss;
      logic [NG-1:0] strb, irq;
      rst_n = 1'b0; hw_trig_en_i = 1'b0; cfg_cont_i = 1'b0; cfg_fast();
      wr_en_i = 1'b0; wr_grp_i = '0; wr_chan_i = '0; wr_ie_i = 1'b0;
      hw_trig_i = '0; cnv_done_i = 1'b1;
      repeat (3) @(negedge clk);
      // reset state
      check(!busy_o && !sampling_o && !cnv_start_o, "R9 reset idle", int'(busy_o), 0);
      check(done_strb_o == '0 && irq_o == '0, "R1 reset strobes", int'(done_strb_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: phase lengths R6 R7 R8 R9, channel R1
      for (int v = 0; v < NV; v++) begin
         cfg_long_i = V_LONG[v][0]; cfg_samp_i = 2'(V_SAMP[v]);
         cfg_div_i  = 2'(V_DIV[v]); cfg_res_i  = 2'(V_RES[v]);
         grp_write(0, 3 + 4 * v, 1'b1);
         check(cnv_chan_o == CW'(3 + 4 * v), "R1 channel", int'(cnv_chan_o), 3 + 4 * v);
         measure(nb, ns, nst, fst, strb, irq);
         check(ns == V_ESMP[v], "R6 sample length", ns, V_ESMP[v]);
         check(nb == V_EBSY[v], "R7 R8 busy length", nb, V_EBSY[v]);
         check(nst == 1 && fst == V_ESMP[v], "R8 start pulse position", fst, V_ESMP[v]);
         check(strb == 4'b0001 && irq == 4'b0001, "R9 strobe", int'(strb), 1);
      end
      cfg_fast();

      // R2: group 1 write never starts in software mode
      grp_write(1, 17, 1'b1);
      quiet_for(10, sb, ss);
      check(sb == 0, "R2 group1 no start", sb, 0);

      // R1: interrupt enable cleared
      grp_write(0, 5, 1'b0);
      measure(nb, ns, nst, fst, strb, irq);
      check(strb == 4'b0001 && irq == 4'b0000, "R1 ie gate", int'(irq), 0);

      // R9: wait for converter done
      cnv_done_i = 1'b0;
      grp_write(0, 5, 1'b1);
      repeat (20) @(negedge clk);
      check(busy_o == 1'b1, "R9 waits for done", int'(busy_o), 1);
      cnv_done_i = 1'b1;
      @(negedge clk);
      check(!busy_o && done_strb_o == 4'b0001, "R9 done completes", int'(done_strb_o), 1);

      // R10: abort in software mode
      grp_write(0, 6, 1'b1);
      repeat (3) @(negedge clk);
      grp_write(0, 6, 1'b1);
      check(!busy_o, "R10 abort idle", int'(busy_o), 0);
      quiet_for(15, sb, ss);
      check(sb == 0 && ss == 0, "R10 no strobe after abort", ss, 0);

      // R11: write to another group while busy
      grp_write(0, 9, 1'b1);
      grp_write(2, 30, 1'b1);
      measure(nb, ns, nst, fst, strb, irq);
      check(nb + 2 == 11, "R11 timing unchanged", nb + 2, 11);
      check(cnv_chan_o == 5'd9 && strb == 4'b0001, "R11 channel unchanged", int'(cnv_chan_o), 9);

      // R3: hardware mode, writes do not start
      hw_trig_en_i = 1'b1;
      grp_write(1, 11, 1'b1);
      grp_write(2, 22, 1'b1);
      grp_write(3, 7, 1'b1);
      grp_write(0, 1, 1'b1);
      quiet_for(5, sb, ss);
      check(sb == 0, "R3 writes no start in hw mode", sb, 0);

      // R3 R4: simultaneous triggers, lowest first
      trig_pulse(4'b0110);
      check(busy_o && act_grp_o == 2'd1 && cnv_chan_o == 5'd11, "R3 trigger starts group", int'(act_grp_o), 1);
      wait_strobe(100, g, w);
      check(g == 1, "R4 first served", g, 1);
      wait_strobe(100, g, w);
      check(g == 2, "R4 second served", g, 2);

      // R4: triggers held while busy, served ascending
      trig_pulse(4'b1000);
      trig_pulse(4'b0011);
      wait_strobe(100, g, w);
      check(g == 3, "R4 running group", g, 3);
      wait_strobe(100, g, w);
      check(g == 0, "R4 held low group", g, 0);
      wait_strobe(100, g, w);
      check(g == 1, "R4 held next group", g, 1);

      // R10: abort drops held trigger of same group
      repeat (3) @(negedge clk);
      trig_pulse(4'b0010);
      trig_pulse(4'b0010);
      grp_write(1, 11, 1'b1);
      quiet_for(20, sb, ss);
      check(sb == 0 && ss == 0, "R10 held trigger dropped", sb, 0);
      hw_trig_en_i = 1'b0;

      // R12: continuous restart
      cfg_cont_i = 1'b1;
      grp_write(0, 4, 1'b1);
      wait_strobe(100, g, w);
      check(g == 0 && busy_o, "R12 restart keeps busy", int'(busy_o), 1);
      for (int k = 0; k < 2; k++) begin
         wait_strobe(100, g, w);
         check(g == 0 && busy_o && w == 11, "R12 repeat period", w, 11);
      end
      grp_write(0, 4, 1'b1);
      cfg_cont_i = 1'b0;
      quiet_for(15, sb, ss);
      check(sb == 0, "R12 stop by abort", sb, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule